// File: doc/BRIEF.md
# SPI Register Transaction Master with Wait-State Polling

This block runs a single register access over a four-wire SPI bus to a security module. A requester gives a direction, a payload length of 1 to 64 bytes and a 24-bit register address, then pulses `start`. The engine pulls chip select low and shifts out a four-byte frame header. It then keeps clocking single polling bytes until the slave signals through bit 0 of a received byte that it is ready. After that it moves the payload in the chosen direction and raises chip select again.

Write payload bytes are pulled from the requester one at a time through a valid/ready handshake. Read bytes are offered on a valid/ready output and held until they are taken. The serial clock idles low and each half period lasts `cfgClkDiv + 1` system clocks. A programmable ceiling on polling bytes stops a slave that never becomes ready: the transaction is abandoned, chip select is released and a timeout strobe is raised in place of the done strobe.

Top module: `spi_regxfer_master`

## Requirements
- R1: The first byte shifted out has bit 7 set for a read and clear for a write, bit 6 always set, and bits 5:0 equal to the byte count minus one.
- R2: The next three bytes carry the register address with bits 23:16 first and bits 7:0 last. Every byte on MOSI goes out most significant bit first.
- R3: A `start` with a byte count of 0 or above 64 pulses `reject` for one cycle in the cycle after `start`. Chip select stays high and `busy` stays low.
- R4: After the header, polling bytes of value 0x00 are shifted out until a received byte has bit 0 (the last bit clocked) equal to 1. Only then does the payload phase begin. The total number of bytes clocked is 5 + stalls + count.
- R5: In a write, each payload byte is taken from `wrData` in a cycle where `wrReady` and `wrValid` are both high, and is shifted out in order.
- R6: In a read, each received payload byte is offered on `rdData` with `rdValid`, held unchanged until `rdReady` is seen, and delivered in order.
- R7: Chip select falls once and rises once per accepted transaction, staying low from the first header bit to the last payload bit. `done` pulses for one cycle as it rises.
- R8: When the number of polling bytes with bit 0 clear reaches `cfgPollLimit` (a value of 0 acts as 1), chip select rises, `timeout` pulses, and no payload handshake takes place.
- R9: SCLK idles low. MISO is sampled on the rising edge, and each high phase lasts `cfgClkDiv + 1` clock cycles.
- R10: `start` has no effect while `busy` is high, including in the cycle `done` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgClkDiv | input | DIV_W | SCLK half period in clocks, minus one |
| cfgPollLimit | input | POLL_W | Maximum number of polling bytes before timeout |
| start | input | 1 | Begin a transaction when idle |
| isRead | input | 1 | 1 for a read, 0 for a write |
| byteCount | input | 7 | Payload length, 1 to 64 |
| regAddr | input | 24 | Register address |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse when polling exceeds the limit |
| reject | output | 1 | One-cycle pulse for an illegal byte count |
| wrData | input | 8 | Write payload byte |
| wrValid | input | 1 | Write byte is present |
| wrReady | output | 1 | Engine takes a write byte |
| rdData | output | 8 | Read payload byte |
| rdValid | output | 1 | Read byte is present |
| rdReady | input | 1 | Requester takes the read byte |
| sclk | output | 1 | SPI serial clock, mode 0 |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The event that can land in the same cycle as another is a new `start` coinciding with the `done` pulse of the current transaction. A careless idle check would launch a second frame at that point. The bench raises `start` with a legal request in exactly the cycle `done` is first seen, and then confirms that chip select never falls again. A second `start` with different direction, address and length is also placed in the middle of a transaction. That case is judged by comparing the captured header with the original request and by counting exactly one chip-select fall.

// File: rtl/spi_regxfer_pkg.sv
package spi_regxfer_pkg;

  localparam int MAX_BYTES = 64;
  localparam int CNT_W     = $clog2(MAX_BYTES) + 1;
  localparam int ADDR_W    = 24;
  localparam int HDR_BYTES = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic       byteGo;
    logic [7:0] txByte;
  } byteCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic       byteDone;
    logic [7:0] rxByte;
  } byteSts_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_POLL, ST_WRGET, ST_XFER, ST_RDPUT, ST_END
  } ctrlState_t;

endpackage

// File: rtl/spi_regxfer_shift.sv
module spi_regxfer_shift
  import spi_regxfer_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  byteCmd_t         cmd,
  output byteSts_t         sts,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);

  logic             active;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       shReg;
  logic             sampled;
  logic             sclkQ;
  logic             byteDoneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= '0;
      shReg     <= '0;
      sampled   <= 1'b0;
      sclkQ     <= 1'b0;
      byteDoneQ <= 1'b0;
    end else begin
      byteDoneQ <= 1'b0;
      if (cmd.byteGo) begin
        active <= 1'b1;
        shReg  <= cmd.txByte;
        divCnt <= '0;
        bitCnt <= '0;
        sclkQ  <= 1'b0;
      end else if (active) begin
        if (divCnt == cfgClkDiv) begin
          divCnt <= '0;
          if (!sclkQ) begin
            // rising edge: capture slave bit
            sclkQ   <= 1'b1;
            sampled <= miso;
          end else begin
            // falling edge: advance both directions
            sclkQ  <= 1'b0;
            shReg  <= {shReg[6:0], sampled};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active    <= 1'b0;
              byteDoneQ <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclk         = sclkQ;
  assign mosi         = shReg[7];
  assign sts.byteDone = byteDoneQ;
  assign sts.rxByte   = shReg;

  // a new byte is only launched while the clock rests low
  p_launch_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.byteGo |-> (!sclkQ && !active));

endmodule

// File: rtl/spi_regxfer_ctrl.sv
module spi_regxfer_ctrl
  import spi_regxfer_pkg::*;
#(
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [POLL_W-1:0] cfgPollLimit,
  input  logic              start,
  input  logic              isRead,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [ADDR_W-1:0] regAddr,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              reject,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              csN,
  output byteCmd_t          cmd,
  input  byteSts_t          sts
);

  localparam int IDX_W = CNT_W - 1;

  ctrlState_t        state;
  logic [IDX_W-1:0]  cntM1Q;
  logic              rdQ;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        hdrIdx;
  logic [IDX_W-1:0]  dataIdx;
  logic [POLL_W-1:0] pollCnt;
  logic              issued;
  logic              toFlag;
  logic [7:0]        wrByteQ;
  logic              rejectQ;
  logic              csNQ;

  logic              countOk;
  logic              lastData;
  logic [POLL_W:0]   limitEff;
  logic [POLL_W:0]   pollNext;

  assign countOk  = (byteCount != '0) && (byteCount <= CNT_W'(MAX_BYTES));
  assign lastData = (dataIdx == cntM1Q);
  assign limitEff = (cfgPollLimit == '0) ? (POLL_W+1)'(1) : {1'b0, cfgPollLimit};
  assign pollNext = {1'b0, pollCnt} + (POLL_W+1)'(1);

  always_comb begin
    cmd.txByte = 8'h00;
    unique case (state)
      ST_HDR: begin
        unique case (hdrIdx)
          2'd0:    cmd.txByte = {rdQ, 1'b1, cntM1Q};
          2'd1:    cmd.txByte = addrQ[23:16];
          2'd2:    cmd.txByte = addrQ[15:8];
          default: cmd.txByte = addrQ[7:0];
        endcase
      end
      ST_XFER: cmd.txByte = rdQ ? 8'h00 : wrByteQ;
      default: cmd.txByte = 8'h00;
    endcase
    cmd.byteGo = ((state == ST_HDR) || (state == ST_POLL) || (state == ST_XFER)) && !issued;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cntM1Q  <= '0;
      rdQ     <= 1'b0;
      addrQ   <= '0;
      hdrIdx  <= '0;
      dataIdx <= '0;
      pollCnt <= '0;
      issued  <= 1'b0;
      toFlag  <= 1'b0;
      wrByteQ <= '0;
      rejectQ <= 1'b0;
      csNQ    <= 1'b1;
    end else begin
      rejectQ <= 1'b0;
      if (cmd.byteGo)        issued <= 1'b1;
      else if (sts.byteDone) issued <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (countOk) begin
              cntM1Q  <= IDX_W'(byteCount - CNT_W'(1));
              rdQ     <= isRead;
              addrQ   <= regAddr;
              hdrIdx  <= '0;
              dataIdx <= '0;
              pollCnt <= '0;
              toFlag  <= 1'b0;
              csNQ    <= 1'b0;
              state   <= ST_HDR;
            end else begin
              rejectQ <= 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (sts.byteDone) begin
            if (hdrIdx == 2'd3) state <= ST_POLL;
            else                hdrIdx <= hdrIdx + 2'd1;
          end
        end
        ST_POLL: begin
          if (sts.byteDone) begin
            if (sts.rxByte[0]) begin
              state <= rdQ ? ST_XFER : ST_WRGET;
            end else if (pollNext >= limitEff) begin
              toFlag <= 1'b1;
              csNQ   <= 1'b1;
              state  <= ST_END;
            end else begin
              pollCnt <= pollNext[POLL_W-1:0];
            end
          end
        end
        ST_WRGET: begin
          if (wrValid) begin
            wrByteQ <= wrData;
            state   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (sts.byteDone) begin
            if (rdQ) begin
              state <= ST_RDPUT;
            end else if (lastData) begin
              csNQ  <= 1'b1;
              state <= ST_END;
            end else begin
              dataIdx <= dataIdx + 1'b1;
              state   <= ST_WRGET;
            end
          end
        end
        ST_RDPUT: begin
          if (rdReady) begin
            if (lastData) begin
              csNQ  <= 1'b1;
              state <= ST_END;
            end else begin
              dataIdx <= dataIdx + 1'b1;
              state   <= ST_XFER;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_END) && !toFlag;
  assign timeout = (state == ST_END) && toFlag;
  assign reject  = rejectQ;
  assign wrReady = (state == ST_WRGET);
  assign rdValid = (state == ST_RDPUT);
  assign rdData  = sts.rxByte;
  assign csN     = csNQ;

  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> (csN && !busy));

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, timeout, reject}));

  p_wr_selected_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !csN);

  p_finish_releases_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |-> (csN && $rose(csN)));

endmodule

// File: rtl/spi_regxfer_master.sv
module spi_regxfer_master
  import spi_regxfer_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgClkDiv,
  input  logic [POLL_W-1:0] cfgPollLimit,
  input  logic              start,
  input  logic              isRead,
  input  logic [6:0]        byteCount,
  input  logic [23:0]       regAddr,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              reject,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);

  byteCmd_t cmd;
  byteSts_t sts;

  spi_regxfer_ctrl #(.POLL_W(POLL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgPollLimit(cfgPollLimit),
    .start(start), .isRead(isRead), .byteCount(byteCount), .regAddr(regAddr),
    .busy(busy), .done(done), .timeout(timeout), .reject(reject),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .csN(csN), .cmd(cmd), .sts(sts)
  );

  spi_regxfer_shift #(.DIV_W(DIV_W)) shift_i (
    .clk(clk), .rstN(rstN), .cfgClkDiv(cfgClkDiv),
    .cmd(cmd), .sts(sts), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  p_no_clock_deselected_r7: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

endmodule

// File: tb/spi_regxfer_master_tb_top.sv
module spi_regxfer_master_tb_top;

  localparam int DIV_W  = 8;
  localparam int POLL_W = 8;
  localparam int SLOTS  = 160;
  // {isRead, count, addr, stalls, div}
  localparam logic [47:0] VEC [5] = '{
    {1'b0, 7'd4,  24'hD40018, 8'd0, 8'd1},
    {1'b1, 7'd4,  24'hD40F00, 8'd3, 8'd0},
    {1'b0, 7'd64, 24'hD40024, 8'd1, 8'd2},
    {1'b1, 7'd1,  24'h123456, 8'd0, 8'd3},
    {1'b1, 7'd64, 24'hABCDEF, 8'd5, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [DIV_W-1:0]  cfgClkDiv = '0;
  logic [POLL_W-1:0] cfgPollLimit = '0;
  logic        start = 0, isRead = 0, wrValid = 0, rdReady = 0;
  logic [6:0]  byteCount = '0;
  logic [23:0] regAddr = '0;
  logic [7:0]  wrData = '0;
  logic busy, done, timeout, reject, wrReady, rdValid, sclk, csN, mosi, miso;
  logic [7:0] rdData;

  spi_regxfer_master #(.DIV_W(DIV_W), .POLL_W(POLL_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgClkDiv(cfgClkDiv), .cfgPollLimit(cfgPollLimit),
    .start(start), .isRead(isRead), .byteCount(byteCount), .regAddr(regAddr),
    .busy(busy), .done(done), .timeout(timeout), .reject(reject),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // slave model
  logic [7:0] slaveTx [SLOTS];
  logic [7:0] mosiLog [SLOTS];
  int sByte = 0, sBit = 0;
  logic [7:0] sShift = '0;
  assign miso = (sByte < SLOTS) ? slaveTx[sByte][7-sBit] : 1'b0;
  always @(posedge sclk) if (!csN) sShift = {sShift[6:0], mosi};
  always @(negedge sclk) if (!csN) begin
    sBit++;
    if (sBit == 8) begin
      sBit = 0;
      if (sByte < SLOTS) mosiLog[sByte] = sShift;
      sByte++;
    end
  end

  int csFall = 0, csRise = 0;
  always @(negedge csN) csFall++;
  always @(posedge csN) csRise++;

  int hiRun = 0, hiBad = 0, expHi = 1;
  bit wrSeen = 0;
  always @(negedge clk) begin
    if (wrReady) wrSeen = 1;
    if (sclk) hiRun++;
    else begin
      if (hiRun != 0 && hiRun != expHi) hiBad++;
      hiRun = 0;
    end
  end

  logic [7:0] rdGot [64];
  int rdIdx, wrIdx, holdBad;
  bit gotDone, gotTo;

  function automatic logic [7:0] wrPat(input logic [23:0] a, input int i);
    return 8'(a[7:0] + 8'(i * 37 + 1));
  endfunction
  function automatic logic [7:0] rdPat(input int i);
    return 8'(8'hC3 ^ 8'(i * 11));
  endfunction

  task automatic runTxn(input logic rd, input int cnt, input logic [23:0] addr,
                        input int stalls, input int div, input int limit,
                        input bit pokeMid, input bit pokeDone);
    int cyc;
    bit holdPending;
    logic [7:0] holdVal;
    bit newR;
    for (int i = 0; i < SLOTS; i++) begin
      slaveTx[i] = 8'hFE;
      mosiLog[i] = 8'h55;
    end
    if (stalls < SLOTS - 70) begin
      slaveTx[4 + stalls] = 8'h03;
      for (int i = 0; i < cnt; i++) slaveTx[5 + stalls + i] = rdPat(i);
    end
    sByte = 0; sBit = 0; csFall = 0; csRise = 0; hiBad = 0; hiRun = 0;
    wrSeen = 0; rdIdx = 0; wrIdx = 0; holdBad = 0; holdPending = 0; holdVal = '0;
    gotDone = 0; gotTo = 0; expHi = div + 1;
    cfgClkDiv = DIV_W'(div); cfgPollLimit = POLL_W'(limit);
    @(negedge clk);
    isRead = rd; byteCount = 7'(cnt); regAddr = addr; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (cyc < 40000) begin
      if (done || timeout) break;
      wrValid = ~wrValid;
      wrData  = wrPat(addr, wrIdx);
      if (wrReady && wrValid) wrIdx++;
      newR = ~rdReady;
      rdReady = newR;
      if (rdValid) begin
        if (holdPending && rdData != holdVal) holdBad++;
        if (newR) begin
          if (rdIdx < 64) rdGot[rdIdx] = rdData;
          rdIdx++; holdPending = 0;
        end else begin
          holdPending = 1; holdVal = rdData;
        end
      end
      if (pokeMid && cyc == 40) begin
        isRead = ~rd; regAddr = ~addr; byteCount = 7'd2; start = 1;
      end else begin
        start = 0; isRead = rd; regAddr = addr; byteCount = 7'(cnt);
      end
      @(negedge clk);
      cyc++;
    end
    gotDone = done; gotTo = timeout;
    if (pokeDone && done) begin
      // R10: start in the same cycle as done
      byteCount = 7'd3; start = 1;
      @(negedge clk);
      start = 0;
    end
    wrValid = 0; rdReady = 0;
    if (cyc >= 40000) chk(0, "R7", "transaction hung", cyc, 0);
  endtask

  task automatic checkFrame(input logic rd, input int cnt, input logic [23:0] addr, input int stalls);
    bit ok;
    chk(gotDone, "R7", "done pulse", int'(gotDone), 1);
    chk(mosiLog[0] == {rd, 1'b1, 6'(cnt - 1)}, "R1", "header byte0", mosiLog[0], {rd, 1'b1, 6'(cnt - 1)});
    chk({mosiLog[1], mosiLog[2], mosiLog[3]} == addr, "R2", "address bytes",
        {mosiLog[1], mosiLog[2], mosiLog[3]}, addr);
    ok = 1;
    for (int i = 4; i <= 4 + stalls; i++) if (mosiLog[i] != 8'h00) ok = 0;
    chk(ok, "R4", "poll bytes zero", int'(ok), 1);
    chk(sByte == 5 + stalls + cnt, "R4", "bytes clocked", sByte, 5 + stalls + cnt);
    if (!rd) begin
      ok = 1;
      for (int i = 0; i < cnt; i++) if (mosiLog[5 + stalls + i] != wrPat(addr, i)) ok = 0;
      chk(ok && wrIdx == cnt, "R5", "write payload", wrIdx, cnt);
    end else begin
      ok = 1;
      for (int i = 0; i < cnt; i++) if (rdGot[i] != rdPat(i)) ok = 0;
      chk(ok && rdIdx == cnt, "R6", "read payload", rdIdx, cnt);
      chk(holdBad == 0, "R6", "read byte held", holdBad, 0);
    end
    chk(csFall == 1 && csRise == 1, "R7", "single select window", csFall * 16 + csRise, 17);
    chk(hiBad == 0, "R9", "sclk high width", hiBad, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(csN && !sclk && !busy && !wrReady && !rdValid, "R7", "reset state",
        {csN, sclk, busy, wrReady, rdValid}, 5'b10000);

    // table of regular transactions
    for (int v = 0; v < 5; v++) begin
      runTxn(VEC[v][47], int'(VEC[v][46:40]), VEC[v][39:16], int'(VEC[v][15:8]),
             int'(VEC[v][7:0]), 16, 0, 0);
      checkFrame(VEC[v][47], int'(VEC[v][46:40]), VEC[v][39:16], int'(VEC[v][15:8]));
    end

    // R3: illegal byte counts
    foreach (VEC[k]) begin end
    for (int t = 0; t < 2; t++) begin
      csFall = 0;
      @(negedge clk);
      byteCount = (t == 0) ? 7'd0 : 7'd65; isRead = 0; start = 1;
      @(negedge clk);
      start = 0;
      chk(reject && csN && !busy, "R3", "reject pulse", {reject, csN, busy}, 3'b110);
      repeat (5) @(negedge clk);
      chk(csFall == 0 && !busy, "R3", "no frame after reject", csFall, 0);
    end

    // R8: poll limit expiry
    runTxn(1'b0, 4, 24'h000024, 200, 0, 3, 0, 0);
    chk(gotTo && !gotDone, "R8", "timeout pulse", {gotTo, gotDone}, 2'b10);
    chk(sByte == 7, "R8", "bytes before abort", sByte, 7);
    chk(!wrSeen && csN && csRise == 1, "R8", "no payload, select released", {wrSeen, csN}, 2'b01);
    runTxn(1'b1, 2, 24'h000018, 200, 1, 0, 0, 0);
    chk(gotTo && sByte == 5, "R8", "zero limit acts as one", sByte, 5);

    // R10: start while busy
    runTxn(1'b0, 3, 24'h5A5A5A, 2, 1, 16, 1, 0);
    checkFrame(1'b0, 3, 24'h5A5A5A, 2);

    // R10: start in the done cycle
    runTxn(1'b1, 2, 24'h0F0F0F, 0, 0, 16, 0, 1);
    f0 = csFall;
    repeat (20) @(negedge clk);
    chk(csFall == f0 && csN && !busy, "R10", "start with done ignored", csFall - f0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule